// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control unit of one DMA channel. Software places the channel's configuration on the inputs and pulses `start`. The configuration covers the transfer mode, unit size, block length, block count, request source, source and destination addresses, the stepping control for each address, and whether the channel reloads. From then on the channel waits for its request. It asks for the bus and, once granted, moves data with alternating read and write cycles. After each write it steps the addresses. It counts down the remaining blocks and reports progress on a 2-bit status output.

Two modes are supported. In burst mode a single accepted request moves block-length × count units without giving up the bus. In demand mode the block length is forced to one. The request is a level, and the channel moves one unit per check of that level. It keeps going while the level holds and drops its bus request as soon as the level goes away. When the count reaches zero, the channel pulses a clear line toward the peripheral that raised the request. If reload is on, it restores its count and addresses and waits for the next request.

Top module: `dma_seq_chan`

## Requirements
- R1: After reset, `stat` is 2'b00 and `bus_req`, `bus_rd`, `bus_wr` and `periph_clr` are all low.
- R2: `start` is taken only while the channel is idle or finished. With `cfg_mode` 2'b01 (burst) or 2'b10 (demand) and a nonzero count, it loads the configuration and `stat` reads 2'b01 on the next cycle. With `cfg_mode` 2'b00 or 2'b11, `start` has no effect and `stat` and `cur_count` keep their values.
- R3: In burst mode one accepted request moves blk × count units. A `cfg_blk` of 0 means 16. `bus_req` stays high without a break from one cycle before the first read until the last write. Each unit is a read cycle followed on the next clock by a write cycle.
- R4: In demand mode `cfg_blk` is ignored and each block is one unit. Transfers continue while the request is active. When the request is inactive, `bus_req` drops, `cur_count` holds and `stat` stays 2'b10 until the level returns.
- R5: Request source: `cfg_sel` 5'b01110 makes a high `dreq` the request, 5'b01111 makes a low `dreq` the request, and values 0 to NP-1 select `periph_req[cfg_sel]`.
- R6: After each write cycle, each address steps by the unit size. `cfg_size` 00, 01, 10 and 11 give 1, 2, 4 and 4 bytes. Its control field selects the direction: 2'b00 increments, 2'b01 decrements, and 2'b1x holds the address.
- R7: `cur_count` drops by one at the end of each block. The write that brings it to zero ends the run, and `stat` becomes 2'b11.
- R8: At the end of a run, `periph_clr` pulses for exactly one cycle, with only bit `cfg_sel` set when the source is a peripheral line. It stays zero when the source is `dreq`.
- R9: With `cfg_reload` set, the end of a run restores `cur_count`, `cur_src` and `cur_dst` to their start values and the channel waits for a new request. `stat` keeps 2'b11 until that request is accepted, then shows 2'b10.
- R10: A start with a zero count sets `stat` to 2'b11 on the next cycle, with no bus request and no clear pulse.
- R11: No read cycle occurs before `bus_gnt`. While the grant is withheld, `bus_req` stays high.
- R12: The data on `bus_wdata` in a write cycle equals the `bus_rdata` captured in the read cycle just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arm the channel with the current configuration |
| cfg_mode | input | 2 | 01 burst, 10 demand |
| cfg_size | input | 2 | Unit size: 1, 2 or 4 bytes |
| cfg_blk | input | 4 | Units per block in burst mode (0 means 16) |
| cfg_count | input | CW | Number of blocks |
| cfg_sel | input | 5 | Request source select |
| cfg_src_ctl | input | 2 | Source address increment, decrement or hold |
| cfg_dst_ctl | input | 2 | Destination address increment, decrement or hold |
| cfg_reload | input | 1 | Re-arm after completion |
| cfg_src | input | AW | Start source address |
| cfg_dst | input | AW | Start destination address |
| dreq | input | 1 | External level request pin |
| periph_req | input | NP | Peripheral request lines |
| bus_gnt | input | 1 | Bus grant |
| bus_rdata | input | DW | Read data |
| bus_req | output | 1 | Bus request |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_addr | output | AW | Cycle address |
| bus_wdata | output | DW | Write data |
| periph_clr | output | NP | One-cycle clear for the requesting peripheral |
| stat | output | 2 | 00 idle, 01 armed, 10 transferring, 11 normal end |
| cur_count | output | CW | Blocks remaining |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |

## Verification
`stat` and `cur_count` respond to `start` one clock later. An active request raises `bus_req` one clock after it is seen. The first read follows one clock after the grant, and each write follows its read by exactly one clock. The bench drives inputs on the falling edge and samples outputs on the next falling edge. On every clock it compares each read and write address and the write data against a queue of expected transfers, which it builds from the configuration. Burst runs are also checked against an exact count of bus-request cycles, 2 × units + 1. The demand pause and the reload wait are checked over a window of several idle cycles, so they do not rely on the exact edge at which the request drops.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ARB, ST_RD, ST_WR, ST_FIN, ST_END
  } dma_state_e;

  localparam logic [1:0] MODE_BURST  = 2'b01;
  localparam logic [1:0] MODE_DEMAND = 2'b10;

  localparam logic [1:0] STAT_IDLE  = 2'b00;
  localparam logic [1:0] STAT_ARMED = 2'b01;
  localparam logic [1:0] STAT_BUSY  = 2'b10;
  localparam logic [1:0] STAT_DONE  = 2'b11;

  localparam int SEL_W = 5;
  localparam logic [SEL_W-1:0] SEL_PIN_HI = 5'b01110;
  localparam logic [SEL_W-1:0] SEL_PIN_LO = 5'b01111;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_seq_pkg::*;
#(
  parameter int NP = 8
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             dreq,
  input  logic [NP-1:0]    preq,
  output logic             req_act,
  output logic [NP-1:0]    clr_mask
);
  for (genvar g = 0; g < NP; g++) begin : g_mask
    assign clr_mask[g] = (sel == SEL_W'(g));
  end

  always_comb begin
    if (sel == SEL_PIN_HI)      req_act = dreq;
    else if (sel == SEL_PIN_LO) req_act = ~dreq;
    else                        req_act = |(preq & clr_mask);
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    ctl,
  input  logic [1:0]    size,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step;
  assign step = AW'(unit_bytes(size));

  always_comb begin
    case (ctl)
      2'b00:   nxt = addr + step;
      2'b01:   nxt = addr - step;
      default: nxt = addr;
    endcase
  end
endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int BLK_W = 4,
  parameter int NP    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_size,
  input  logic [BLK_W-1:0] cfg_blk,
  input  logic [CW-1:0]    cfg_count,
  input  logic [4:0]       cfg_sel,
  input  logic [1:0]       cfg_src_ctl,
  input  logic [1:0]       cfg_dst_ctl,
  input  logic             cfg_reload,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic             dreq,
  input  logic [NP-1:0]    periph_req,
  input  logic             bus_gnt,
  input  logic [DW-1:0]    bus_rdata,
  output logic             bus_req,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  output logic [NP-1:0]    periph_clr,
  output logic [1:0]       stat,
  output logic [CW-1:0]    cur_count,
  output logic [AW-1:0]    cur_src,
  output logic [AW-1:0]    cur_dst
);
  localparam int BLW = BLK_W + 1;

  dma_state_e       state;
  logic [1:0]       mode_q, size_q, sctl_q, dctl_q, stat_q;
  logic [4:0]       sel_q;
  logic             reload_q;
  logic [BLW-1:0]   blk_len_q, left_q;
  logic [CW-1:0]    cnt_q, sh_cnt;
  logic [AW-1:0]    src_q, dst_q, sh_src, sh_dst, src_nxt, dst_nxt;
  logic [DW-1:0]    data_q;
  logic [NP-1:0]    clr_q, clr_mask;
  logic             req_act, mode_ok;
  logic [BLW-1:0]   blk_load;

  dma_req_sel #(.NP(NP)) u_req (
    .sel(sel_q), .dreq(dreq), .preq(periph_req),
    .req_act(req_act), .clr_mask(clr_mask)
  );

  dma_addr_step #(.AW(AW)) u_src_step (
    .addr(src_q), .ctl(sctl_q), .size(size_q), .nxt(src_nxt)
  );

  dma_addr_step #(.AW(AW)) u_dst_step (
    .addr(dst_q), .ctl(dctl_q), .size(size_q), .nxt(dst_nxt)
  );

  assign mode_ok  = (cfg_mode == MODE_BURST) || (cfg_mode == MODE_DEMAND);
  assign blk_load = (cfg_mode == MODE_DEMAND) ? BLW'(1) :
                    (cfg_blk == '0) ? {1'b1, {BLK_W{1'b0}}} : {1'b0, cfg_blk};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      stat_q    <= STAT_IDLE;
      clr_q     <= '0;
      mode_q    <= '0;
      size_q    <= '0;
      sctl_q    <= '0;
      dctl_q    <= '0;
      sel_q     <= '0;
      reload_q  <= 1'b0;
      blk_len_q <= '0;
      left_q    <= '0;
      cnt_q     <= '0;
      sh_cnt    <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      sh_src    <= '0;
      sh_dst    <= '0;
      data_q    <= '0;
    end else begin
      clr_q <= '0;
      case (state)
        ST_IDLE, ST_END: begin
          if (start && mode_ok) begin
            mode_q    <= cfg_mode;
            size_q    <= cfg_size;
            sctl_q    <= cfg_src_ctl;
            dctl_q    <= cfg_dst_ctl;
            sel_q     <= cfg_sel;
            reload_q  <= cfg_reload;
            blk_len_q <= blk_load;
            left_q    <= blk_load;
            cnt_q     <= cfg_count;
            sh_cnt    <= cfg_count;
            src_q     <= cfg_src;
            dst_q     <= cfg_dst;
            sh_src    <= cfg_src;
            sh_dst    <= cfg_dst;
            if (cfg_count == '0) begin
              state  <= ST_END;
              stat_q <= STAT_DONE;
            end else begin
              state  <= ST_WAIT;
              stat_q <= STAT_ARMED;
            end
          end
        end
        ST_WAIT: begin
          if (req_act) begin
            state  <= ST_ARB;
            stat_q <= STAT_BUSY;
          end
        end
        ST_ARB: if (bus_gnt) state <= ST_RD;
        ST_RD: begin
          data_q <= bus_rdata;
          state  <= ST_WR;
        end
        ST_WR: begin
          src_q <= src_nxt;
          dst_q <= dst_nxt;
          if (left_q == BLW'(1)) begin
            cnt_q  <= cnt_q - CW'(1);
            left_q <= blk_len_q;
            if (cnt_q == CW'(1)) begin
              state  <= ST_FIN;
              stat_q <= STAT_DONE;
              clr_q  <= clr_mask;
            end else if (mode_q == MODE_BURST || req_act) begin
              state <= ST_RD;
            end else begin
              state <= ST_WAIT;
            end
          end else begin
            left_q <= left_q - BLW'(1);
            state  <= ST_RD;
          end
        end
        ST_FIN: begin
          if (reload_q) begin
            cnt_q  <= sh_cnt;
            src_q  <= sh_src;
            dst_q  <= sh_dst;
            left_q <= blk_len_q;
            state  <= ST_WAIT;
          end else begin
            state <= ST_END;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_req    = (state == ST_ARB) || (state == ST_RD) || (state == ST_WR);
  assign bus_rd     = (state == ST_RD);
  assign bus_wr     = (state == ST_WR);
  assign bus_addr   = (state == ST_RD) ? src_q : dst_q;
  assign bus_wdata  = data_q;
  assign periph_clr = clr_q;
  assign stat       = stat_q;
  assign cur_count  = cnt_q;
  assign cur_src    = src_q;
  assign cur_dst    = dst_q;
endmodule

// File: rtl/dma_seq_chan_chk.sv
module dma_seq_chan_chk #(
  parameter int NP = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          bus_req,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [NP-1:0] periph_clr,
  input logic [1:0]    stat,
  input logic [CW-1:0] cur_count
);
  p_rw_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_wr);

  p_bus_owned_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> bus_req);

  p_clr_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(periph_clr));

  p_clr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (|periph_clr) |=> (periph_clr == '0));

  p_clr_done_r7: assert property (@(posedge clk) disable iff (rst)
    (|periph_clr) |-> (stat == 2'b11));

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(start) && $past(stat) != 2'b11 && cur_count != $past(cur_count))
      |-> (cur_count == $past(cur_count) - CW'(1)));
endmodule

bind dma_seq_chan dma_seq_chan_chk #(.NP(NP), .CW(CW)) u_chk (.*);

// File: tb/tb_dma_seq_chan.sv
`timescale 1ns/1ps
module tb_dma_seq_chan;
  localparam int AW = 32, DW = 32, CW = 16, NP = 8;
  localparam logic [31:0] RD_KEY = 32'h5A5A_0F0F;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] cfg_mode = '0, cfg_size = '0, cfg_src_ctl = '0, cfg_dst_ctl = '0;
  logic [3:0] cfg_blk = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [4:0] cfg_sel = '0;
  logic cfg_reload = 1'b0, dreq = 1'b0, bus_gnt = 1'b1;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [NP-1:0] periph_req, preq_set = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_req, bus_rd, bus_wr;
  logic [AW-1:0] bus_addr, cur_src, cur_dst;
  logic [DW-1:0] bus_wdata;
  logic [NP-1:0] periph_clr;
  logic [1:0] stat;
  logic [CW-1:0] cur_count;

  int n_tests = 0, n_fail = 0;
  int xfers = 0, req_cycles = 0, clr_seen = 0, rd_seen = 0;
  logic [NP-1:0] clr_val = '0;
  logic [AW-1:0] q_src[$], q_dst[$];

  always #2.5 clk = ~clk;

  dma_seq_chan #(.AW(AW), .DW(DW), .CW(CW), .BLK_W(4), .NP(NP)) dut (.*);

  assign bus_rdata = bus_addr ^ RD_KEY;

  // peripheral model: request stays up until the channel clears it
  always @(posedge clk) begin
    if (rst) periph_req <= '0;
    else     periph_req <= (periph_req | preq_set) & ~periph_clr;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the expected transfer queue
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req) req_cycles++;
      if (|periph_clr) begin clr_seen++; clr_val = periph_clr; end
      if (bus_rd) begin
        rd_seen++;
        if (q_src.size() == 0) chk(0, "R3 unexpected read", 64'(bus_addr), 0);
        else chk(bus_addr == q_src[0], "R6 read address", 64'(bus_addr), 64'(q_src[0]));
      end
      if (bus_wr) begin
        if (q_dst.size() == 0) chk(0, "R3 unexpected write", 64'(bus_addr), 0);
        else begin
          chk(bus_addr == q_dst[0], "R6 write address", 64'(bus_addr), 64'(q_dst[0]));
          chk(bus_wdata == (q_src[0] ^ RD_KEY), "R12 write data", 64'(bus_wdata), 64'(q_src[0] ^ RD_KEY));
          void'(q_src.pop_front());
          void'(q_dst.pop_front());
        end
        xfers++;
      end
    end
  end

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] ctl, input logic [1:0] sz);
    int b = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    if (ctl == 2'b00) return a + AW'(b);
    if (ctl == 2'b01) return a - AW'(b);
    return a;
  endfunction

  task automatic expect_xfers(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n);
    logic [AW-1:0] a = s, b = d;
    for (int i = 0; i < n; i++) begin
      q_src.push_back(a);
      q_dst.push_back(b);
      a = step(a, cfg_src_ctl, cfg_size);
      b = step(b, cfg_dst_ctl, cfg_size);
    end
  endtask

  task automatic clear_stats();
    xfers = 0; req_cycles = 0; clr_seen = 0; rd_seen = 0; clr_val = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_stats();
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] sz, input logic [3:0] blk,
                       input logic [CW-1:0] c, input logic [4:0] sel, input logic [1:0] sc,
                       input logic [1:0] dc, input logic [AW-1:0] s, input logic [AW-1:0] d,
                       input logic rl);
    cfg_mode = m; cfg_size = sz; cfg_blk = blk; cfg_count = c; cfg_sel = sel;
    cfg_src_ctl = sc; cfg_dst_ctl = dc; cfg_src = s; cfg_dst = d; cfg_reload = rl;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_preq(input logic [NP-1:0] m);
    @(negedge clk); preq_set = m;
    @(negedge clk); preq_set = '0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (stat != 2'b11 && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [CW-1:0] held;
    do_reset();
    // R1 reset state
    chk(stat == 2'b00, "R1 stat", 64'(stat), 0);
    chk({bus_req, bus_rd, bus_wr} == 3'b000, "R1 bus strobes", 64'({bus_req, bus_rd, bus_wr}), 0);
    chk(periph_clr == '0, "R1 clear lines", 64'(periph_clr), 0);

    // R2 invalid modes ignored
    setup(2'b00, 2'b10, 4'd2, 16'd5, 5'd1, 2'b00, 2'b00, 32'h10, 32'h20, 1'b0);
    pulse_start();
    chk(stat == 2'b00 && cur_count == '0, "R2 mode 00 ignored", 64'({stat, cur_count}), 0);
    cfg_mode = 2'b11;
    pulse_start();
    repeat (3) @(negedge clk);
    chk(stat == 2'b00 && cur_count == '0 && req_cycles == 0, "R2 mode 11 ignored",
        64'({stat, cur_count}), 0);

    // R3 R6 R7 R8 burst from peripheral line 2
    setup(2'b01, 2'b10, 4'd3, 16'd4, 5'd2, 2'b00, 2'b00, 32'h1000, 32'h2000, 1'b0);
    expect_xfers(32'h1000, 32'h2000, 12);
    pulse_start();
    chk(stat == 2'b01, "R2 armed", 64'(stat), 1);
    chk(cur_count == 16'd4, "R2 count loaded", 64'(cur_count), 4);
    pulse_preq(8'b0000_0100);
    wait_done();
    chk(xfers == 12, "R3 burst units", 64'(xfers), 12);
    chk(req_cycles == 25, "R3 bus held through burst", 64'(req_cycles), 25);
    chk(q_src.size() == 0, "R3 queue drained", 64'(q_src.size()), 0);
    chk(cur_count == '0 && stat == 2'b11, "R7 end state", 64'({stat, cur_count}), 64'h3_0000);
    chk(clr_seen == 1 && clr_val == 8'b0000_0100, "R8 clear pulse", 64'({clr_seen, clr_val}), 64'h104);
    chk(cur_src == 32'h1030 && cur_dst == 32'h2030, "R6 final addresses", 64'(cur_src), 64'h1030);

    // R3 R5 R6 block 10 x count 16 from high dreq, src held, dst decrements
    clear_stats();
    dreq = 1'b1;
    setup(2'b01, 2'b10, 4'd10, 16'd16, 5'b01110, 2'b10, 2'b01, 32'h4000, 32'h8000, 1'b0);
    expect_xfers(32'h4000, 32'h8000, 160);
    pulse_start();
    wait_done();
    dreq = 1'b0;
    chk(xfers == 160, "R3 ten by sixteen units", 64'(xfers), 160);
    chk(req_cycles == 321, "R3 bus held", 64'(req_cycles), 321);
    chk(clr_seen == 0, "R8 no clear for pin source", 64'(clr_seen), 0);
    chk(cur_src == 32'h4000 && cur_dst == 32'h8000 - 32'd640, "R6 held and decremented",
        64'(cur_dst), 64'(32'h8000 - 32'd640));

    // R4 R5 demand, high dreq, blk ignored, halfword, src decrements
    clear_stats();
    setup(2'b10, 2'b01, 4'd7, 16'd5, 5'b01110, 2'b01, 2'b00, 32'h600, 32'h700, 1'b0);
    expect_xfers(32'h600, 32'h700, 5);
    pulse_start();
    chk(stat == 2'b01, "R2 demand armed", 64'(stat), 1);
    repeat (4) @(negedge clk);
    chk(req_cycles == 0 && cur_count == 16'd5, "R5 idle without dreq", 64'(req_cycles), 0);
    dreq = 1'b1;
    while (xfers < 2) @(negedge clk);
    dreq = 1'b0;
    repeat (6) @(negedge clk);
    held = cur_count;
    chk(bus_req == 1'b0, "R4 bus released", 64'(bus_req), 0);
    repeat (4) @(negedge clk);
    chk(cur_count == held && held != '0, "R4 count holds", 64'(cur_count), 64'(held));
    chk(stat == 2'b10, "R4 stat during pause", 64'(stat), 2);
    dreq = 1'b1;
    wait_done();
    dreq = 1'b0;
    chk(xfers == 5, "R4 one unit per block", 64'(xfers), 5);
    chk(cur_src == 32'h600 - 32'd10, "R6 halfword decrement", 64'(cur_src), 64'(32'h600 - 32'd10));

    // R5 demand, low-active dreq, byte units
    clear_stats();
    dreq = 1'b1;
    setup(2'b10, 2'b00, 4'd0, 16'd3, 5'b01111, 2'b00, 2'b00, 32'h30, 32'h50, 1'b0);
    expect_xfers(32'h30, 32'h50, 3);
    pulse_start();
    repeat (5) @(negedge clk);
    chk(req_cycles == 0, "R5 high level inactive", 64'(req_cycles), 0);
    dreq = 1'b0;
    wait_done();
    dreq = 1'b1;
    chk(xfers == 3 && cur_src == 32'h33, "R5 low level active", 64'(cur_src), 64'h33);

    // R11 grant withheld
    clear_stats();
    bus_gnt = 1'b0;
    setup(2'b01, 2'b11, 4'd2, 16'd1, 5'd5, 2'b00, 2'b00, 32'h900, 32'hA00, 1'b0);
    expect_xfers(32'h900, 32'hA00, 2);
    pulse_start();
    pulse_preq(8'b0010_0000);
    repeat (6) @(negedge clk);
    chk(bus_req == 1'b1 && rd_seen == 0, "R11 waits for grant", 64'({bus_req, rd_seen}), 64'h1_0000_0000);
    bus_gnt = 1'b1;
    wait_done();
    chk(xfers == 2 && clr_val == 8'b0010_0000, "R11 R8 after grant", 64'({xfers, clr_val}), 64'h220);

    // R10 zero count
    do_reset();
    setup(2'b01, 2'b10, 4'd1, 16'd0, 5'd0, 2'b00, 2'b00, 32'h0, 32'h0, 1'b0);
    pulse_start();
    chk(stat == 2'b11, "R10 immediate end", 64'(stat), 3);
    repeat (5) @(negedge clk);
    chk(req_cycles == 0 && clr_seen == 0, "R10 no activity", 64'({req_cycles, clr_seen}), 0);

    // R9 reload
    do_reset();
    setup(2'b01, 2'b10, 4'd2, 16'd2, 5'd3, 2'b00, 2'b00, 32'h100, 32'h200, 1'b1);
    expect_xfers(32'h100, 32'h200, 4);
    expect_xfers(32'h100, 32'h200, 4);
    pulse_start();
    pulse_preq(8'b0000_1000);
    wait_done();
    repeat (3) @(negedge clk);
    chk(stat == 2'b11 && bus_req == 1'b0, "R9 waits with done status", 64'({stat, bus_req}), 64'h6);
    chk(cur_count == 16'd2, "R9 count restored", 64'(cur_count), 2);
    chk(cur_src == 32'h100 && cur_dst == 32'h200, "R9 addresses restored", 64'(cur_src), 64'h100);
    chk(xfers == 4, "R9 first run", 64'(xfers), 4);
    pulse_preq(8'b0000_1000);
    @(negedge clk);
    chk(stat == 2'b10, "R9 busy on new request", 64'(stat), 2);
    wait_done();
    chk(xfers == 8 && q_src.size() == 0, "R9 second run", 64'(xfers), 8);

    report();
  end
endmodule